// File: doc/BRIEF.md
# Flash Command Sequence Controller

This block is the command front end of a NOR-style flash device. It watches the host bus, turns each qualifying write pulse into a single command event, and runs the multi-write unlock protocols that protect the array. Two protected commands are decoded. The first is program, which hands an address and data word to the internal program engine. The second is identification, which makes reads return manufacturer and device codes instead of array contents. A reset-to-read command drops the identification mode.

The bus may run in word mode (x16) or byte mode (x8). The unlock addresses and the identification offsets depend on the mode, and the bank is taken from the upper part of the word address in both modes. The program engine is modelled by a cycle counter. While the counter runs, the ready flag is low and every write is discarded. When it expires, the block returns to array reads.

Top module: `flash_cmd_ctrl`

## Requirements
- R1: A bus write counts only while ce_n=0, we_n=0 and oe_n=1. A pulse with oe_n low has no effect on the command sequence.
- R2: A write's address is the value on addr in the first sampled cycle of the pulse. Its data is the value on dq in the last sampled cycle of the pulse.
- R3: In word mode (byte_mode=0), the writes AAh@555h, 55h@2AAh, A0h@555h followed by one more write (comparing addr[10:0] and dq[7:0]) produce a one-cycle prog_req with prog_addr and prog_data equal to that last write.
- R4: In byte mode (byte_mode=1), the unlock addresses are compared on addr[11:0] as AAAh, 555h and AAAh. Word-mode addresses do not unlock in byte mode.
- R5: The writes AAh, 55h, 90h (third write at the first unlock address) set id_mode=1. In id_mode, a read with addr[7:0]=00h in the identified bank returns ECh. Offset 01h (word mode) returns 22A2h and offset 02h (byte mode) returns 0022h. Any other offset in that bank returns 0.
- R6: The bank is word_addr[20:19], where word_addr is addr[20:0] in word mode and addr[21:1] in byte mode. A program data write in a bank other than that of the third write is dropped and the sequence returns to idle. In id_mode, reads from other banks return array_rdata.
- R7: A write of F0h clears id_mode and aborts a partly entered sequence. Other writes leave id_mode set.
- R8: A write that does not match the expected address and data for the current step returns the sequence to idle.
- R9: ready falls in the same cycle that prog_req rises and stays low for exactly PROG_CYCLES cycles.
- R10: Every write that completes while ready is low is ignored, including one that completes in the last busy cycle.
- R11: After the program ends, reads return array_rdata and a new sequence is accepted in the very next cycle.
- R12: Synchronous reset forces ready=1, prog_req=0, id_mode=0 and rd_data=0, and discards any partial sequence.
- R13: rd_data is registered: it reflects addr and array_rdata one clock after they are presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; bus pins are sampled on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| byte_mode | input | 1 | 1 = x8 byte addressing, 0 = x16 word addressing |
| ce_n | input | 1 | Chip enable, active low |
| we_n | input | 1 | Write enable, active low |
| oe_n | input | 1 | Output enable, active low |
| addr | input | ADDR_W | Bus address (byte address in x8 mode) |
| dq | input | DATA_W | Write data from the host |
| array_rdata | input | DATA_W | Array contents for the current address |
| rd_data | output | DATA_W | Registered read data: array contents or identification code |
| ready | output | 1 | 1 = ready, 0 = program in progress |
| prog_req | output | 1 | One-cycle program start pulse |
| prog_addr | output | ADDR_W | Address of the program request |
| prog_data | output | DATA_W | Data of the program request |
| id_mode | output | 1 | Identification read mode active |

## Verification
The overlap that matters is a bus write completing in the same cycle that the program counter expires. At that edge the decoder both leaves its busy state and sees a new command event. The bench counts negative edges from the observed prog_req and places the first unlock write of an identification sequence either one cycle before or exactly at the first ready cycle. The verdict comes from id_mode: it must stay low when the unlock write lands in the final busy cycle, and it must rise when the write lands one cycle later.

// File: rtl/flash_cmd_pkg.sv
`timescale 1ns/1ps
package flash_cmd_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_UNL1,
    ST_UNL2,
    ST_ARMED,
    ST_IDMODE,
    ST_BUSY
  } seq_state_t;

  localparam logic [7:0] CMD_KEY1  = 8'hAA;
  localparam logic [7:0] CMD_KEY2  = 8'h55;
  localparam logic [7:0] CMD_PROG  = 8'hA0;
  localparam logic [7:0] CMD_IDENT = 8'h90;
  localparam logic [7:0] CMD_READ  = 8'hF0;

  localparam logic [10:0] KEYA_X16 = 11'h555;
  localparam logic [10:0] KEYB_X16 = 11'h2AA;
  localparam logic [11:0] KEYA_X8  = 12'hAAA;
  localparam logic [11:0] KEYB_X8  = 12'h555;

  localparam logic [7:0] OFS_MFR     = 8'h00;
  localparam logic [7:0] OFS_DEV_X16 = 8'h01;
  localparam logic [7:0] OFS_DEV_X8  = 8'h02;

endpackage

// File: rtl/fcc_bus_capture.sv
`timescale 1ns/1ps
module fcc_bus_capture #(
  parameter int ADDR_W = 22,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ce_n,
  input  logic              we_n,
  input  logic              oe_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] dq,
  output logic              wr_done,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [DATA_W-1:0] wr_data
);

  logic              wr_act;
  logic              wr_act_q;
  logic [ADDR_W-1:0] addr_hold;
  logic [DATA_W-1:0] data_hold;

  // a qualified write pulse: both strobes low, outputs disabled
  assign wr_act = !ce_n && !we_n && oe_n;

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_act_q  <= 1'b0;
      addr_hold <= '0;
      data_hold <= '0;
      wr_done   <= 1'b0;
      wr_addr   <= '0;
      wr_data   <= '0;
    end else begin
      wr_act_q <= wr_act;
      // address frozen on the leading edge of the pulse
      if (wr_act && !wr_act_q) addr_hold <= addr;
      // data keeps tracking until the trailing edge
      if (wr_act) data_hold <= dq;
      wr_done <= wr_act_q && !wr_act;
      if (wr_act_q && !wr_act) begin
        wr_addr <= addr_hold;
        wr_data <= data_hold;
      end
    end
  end

  assert_single_event_R2: assert property (@(posedge clk) disable iff (rst)
    wr_done |=> !wr_done);

  assert_event_after_pulse_R1: assert property (@(posedge clk) disable iff (rst)
    $rose(wr_done) |-> $past(wr_act_q));

endmodule

// File: rtl/fcc_prog_timer.sv
`timescale 1ns/1ps
module fcc_prog_timer #(
  parameter int PROG_CYCLES = 64
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  output logic ready,
  output logic finishing
);

  localparam int CNT_W = $clog2(PROG_CYCLES + 1);

  logic [CNT_W-1:0] cnt;

  assign finishing = !ready && (cnt == CNT_W'(1));

  always_ff @(posedge clk) begin
    if (rst) begin
      ready <= 1'b1;
      cnt   <= '0;
    end else if (start) begin
      ready <= 1'b0;
      cnt   <= CNT_W'(PROG_CYCLES);
    end else if (!ready) begin
      if (finishing) begin
        ready <= 1'b1;
        cnt   <= '0;
      end else begin
        cnt <= cnt - CNT_W'(1);
      end
    end
  end

  assert_ready_fall_R9: assert property (@(posedge clk) disable iff (rst)
    $fell(ready) |-> $past(start));

  assert_count_bound_R9: assert property (@(posedge clk) disable iff (rst)
    !ready |-> (cnt != '0 && cnt <= CNT_W'(PROG_CYCLES)));

endmodule

// File: rtl/fcc_decoder.sv
`timescale 1ns/1ps
module fcc_decoder
  import flash_cmd_pkg::*;
#(
  parameter int ADDR_W = 22,
  parameter int DATA_W = 16,
  parameter int BANK_W = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              byte_mode,
  input  logic              wr_done,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              finishing,
  output logic              go,
  output logic              prog_req,
  output logic [ADDR_W-1:0] prog_addr,
  output logic [DATA_W-1:0] prog_data,
  output logic              id_mode,
  output logic [BANK_W-1:0] id_bank
);

  localparam int WA_W = ADDR_W - 1;

  seq_state_t        state;
  seq_state_t        st_nx;
  logic [WA_W-1:0]   word_addr;
  logic [BANK_W-1:0] wr_bank;
  logic [BANK_W-1:0] seq_bank;
  logic [7:0]        cmd;
  logic              key_a;
  logic              key_b;
  logic              latch_bank;

  assign word_addr = byte_mode ? wr_addr[ADDR_W-1:1] : wr_addr[WA_W-1:0];
  assign wr_bank   = word_addr[WA_W-1 -: BANK_W];
  assign cmd       = wr_data[7:0];
  assign key_a     = byte_mode ? (wr_addr[11:0] == KEYA_X8)
                               : (wr_addr[10:0] == KEYA_X16);
  assign key_b     = byte_mode ? (wr_addr[11:0] == KEYB_X8)
                               : (wr_addr[10:0] == KEYB_X16);

  always_comb begin
    st_nx      = state;
    go         = 1'b0;
    latch_bank = 1'b0;
    case (state)
      ST_IDLE: begin
        if (wr_done && key_a && cmd == CMD_KEY1) st_nx = ST_UNL1;
      end
      ST_UNL1: begin
        if (wr_done) st_nx = (key_b && cmd == CMD_KEY2) ? ST_UNL2 : ST_IDLE;
      end
      ST_UNL2: begin
        if (wr_done) begin
          latch_bank = 1'b1;
          if (key_a && cmd == CMD_PROG)       st_nx = ST_ARMED;
          else if (key_a && cmd == CMD_IDENT) st_nx = ST_IDMODE;
          else                                st_nx = ST_IDLE;
        end
      end
      ST_ARMED: begin
        if (wr_done) begin
          if (wr_bank == seq_bank) begin
            go    = 1'b1;
            st_nx = ST_BUSY;
          end else begin
            st_nx = ST_IDLE;
          end
        end
      end
      ST_IDMODE: begin
        if (wr_done && cmd == CMD_READ) st_nx = ST_IDLE;
      end
      ST_BUSY: begin
        // writes are discarded; only the engine ends this state
        if (finishing) st_nx = ST_IDLE;
      end
      default: st_nx = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      seq_bank  <= '0;
      prog_req  <= 1'b0;
      prog_addr <= '0;
      prog_data <= '0;
      id_mode   <= 1'b0;
    end else begin
      state    <= st_nx;
      prog_req <= go;
      id_mode  <= (st_nx == ST_IDMODE);
      if (latch_bank) seq_bank <= wr_bank;
      if (go) begin
        prog_addr <= wr_addr;
        prog_data <= wr_data;
      end
    end
  end

  assign id_bank = seq_bank;

  assert_prog_from_armed_R3: assert property (@(posedge clk) disable iff (rst)
    prog_req |-> $past(state) == ST_ARMED);

  assert_prog_pulse_R3: assert property (@(posedge clk) disable iff (rst)
    prog_req |=> !prog_req);

  assert_busy_ignores_R10: assert property (@(posedge clk) disable iff (rst)
    (state == ST_BUSY && wr_done) |=> (!prog_req && !id_mode));

  assert_exit_id_R7: assert property (@(posedge clk) disable iff (rst)
    (state == ST_IDMODE && wr_done && wr_data[7:0] == CMD_READ) |=> !id_mode);

  assert_mismatch_idle_R8: assert property (@(posedge clk) disable iff (rst)
    (state == ST_UNL1 && wr_done && wr_data[7:0] != CMD_KEY2) |=> state == ST_IDLE);

endmodule

// File: rtl/fcc_read_mux.sv
`timescale 1ns/1ps
module fcc_read_mux
  import flash_cmd_pkg::*;
#(
  parameter int          ADDR_W  = 22,
  parameter int          DATA_W  = 16,
  parameter int          BANK_W  = 2,
  parameter logic [15:0] MFR_ID  = 16'h00EC,
  parameter logic [15:0] DEV_X16 = 16'h22A2,
  parameter logic [15:0] DEV_X8  = 16'h0022
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              byte_mode,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] array_rdata,
  input  logic              id_mode,
  input  logic [BANK_W-1:0] id_bank,
  output logic [DATA_W-1:0] rd_data
);

  localparam int WA_W = ADDR_W - 1;

  logic [WA_W-1:0]   word_addr;
  logic [BANK_W-1:0] rd_bank;
  logic [7:0]        ofs;
  logic [DATA_W-1:0] id_word;
  logic [DATA_W-1:0] rd_nx;

  assign word_addr = byte_mode ? addr[ADDR_W-1:1] : addr[WA_W-1:0];
  assign rd_bank   = word_addr[WA_W-1 -: BANK_W];
  assign ofs       = addr[7:0];

  always_comb begin
    id_word = '0;
    if (ofs == OFS_MFR)                      id_word = DATA_W'(MFR_ID);
    else if (!byte_mode && ofs == OFS_DEV_X16) id_word = DATA_W'(DEV_X16);
    else if (byte_mode && ofs == OFS_DEV_X8)   id_word = DATA_W'(DEV_X8);
    rd_nx = (id_mode && rd_bank == id_bank) ? id_word : array_rdata;
  end

  always_ff @(posedge clk) begin
    if (rst) rd_data <= '0;
    else     rd_data <= rd_nx;
  end

  assert_array_path_R11: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(id_mode)) |-> rd_data == $past(array_rdata));

endmodule

// File: rtl/flash_cmd_ctrl.sv
`timescale 1ns/1ps
module flash_cmd_ctrl #(
  parameter int          ADDR_W      = 22,
  parameter int          DATA_W      = 16,
  parameter int          BANK_W      = 2,
  parameter int          PROG_CYCLES = 64,
  parameter logic [15:0] MFR_ID      = 16'h00EC,
  parameter logic [15:0] DEV_X16     = 16'h22A2,
  parameter logic [15:0] DEV_X8      = 16'h0022
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              byte_mode,
  input  logic              ce_n,
  input  logic              we_n,
  input  logic              oe_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] dq,
  input  logic [DATA_W-1:0] array_rdata,
  output logic [DATA_W-1:0] rd_data,
  output logic              ready,
  output logic              prog_req,
  output logic [ADDR_W-1:0] prog_addr,
  output logic [DATA_W-1:0] prog_data,
  output logic              id_mode
);

  logic              wr_done;
  logic [ADDR_W-1:0] wr_addr;
  logic [DATA_W-1:0] wr_data;
  logic              go;
  logic              finishing;
  logic [BANK_W-1:0] id_bank;

  fcc_bus_capture #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_cap (
    .clk(clk), .rst(rst), .ce_n(ce_n), .we_n(we_n), .oe_n(oe_n),
    .addr(addr), .dq(dq),
    .wr_done(wr_done), .wr_addr(wr_addr), .wr_data(wr_data)
  );

  fcc_decoder #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .BANK_W(BANK_W)) u_dec (
    .clk(clk), .rst(rst), .byte_mode(byte_mode),
    .wr_done(wr_done), .wr_addr(wr_addr), .wr_data(wr_data),
    .finishing(finishing), .go(go),
    .prog_req(prog_req), .prog_addr(prog_addr), .prog_data(prog_data),
    .id_mode(id_mode), .id_bank(id_bank)
  );

  fcc_prog_timer #(.PROG_CYCLES(PROG_CYCLES)) u_tmr (
    .clk(clk), .rst(rst), .start(go),
    .ready(ready), .finishing(finishing)
  );

  fcc_read_mux #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .BANK_W(BANK_W),
    .MFR_ID(MFR_ID), .DEV_X16(DEV_X16), .DEV_X8(DEV_X8)
  ) u_rd (
    .clk(clk), .rst(rst), .byte_mode(byte_mode), .addr(addr),
    .array_rdata(array_rdata), .id_mode(id_mode), .id_bank(id_bank),
    .rd_data(rd_data)
  );

  assert_req_drops_ready_R9: assert property (@(posedge clk) disable iff (rst)
    $rose(prog_req) |-> !ready);

  assert_busy_no_id_R10: assert property (@(posedge clk) disable iff (rst)
    !ready |-> !id_mode);

endmodule

// File: tb/flash_cmd_ctrl_test.sv
`timescale 1ns/1ps
module flash_cmd_ctrl_test;

  localparam int ADDR_W = 22;
  localparam int DATA_W = 16;
  localparam int P      = 12;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              byte_mode = 1'b0;
  logic              ce_n = 1'b1;
  logic              we_n = 1'b1;
  logic              oe_n = 1'b1;
  logic [ADDR_W-1:0] addr = '0;
  logic [DATA_W-1:0] dq = '0;
  logic [DATA_W-1:0] array_rdata = 16'h5A5A;
  logic [DATA_W-1:0] rd_data;
  logic              ready;
  logic              prog_req;
  logic [ADDR_W-1:0] prog_addr;
  logic [DATA_W-1:0] prog_data;
  logic              id_mode;

  int tests = 0;
  int fails = 0;
  logic [ADDR_W+DATA_W-1:0] exp_q[$];

  always #10 clk = ~clk;

  flash_cmd_ctrl #(.PROG_CYCLES(P)) uut (
    .clk(clk), .rst(rst), .byte_mode(byte_mode), .ce_n(ce_n), .we_n(we_n),
    .oe_n(oe_n), .addr(addr), .dq(dq), .array_rdata(array_rdata),
    .rd_data(rd_data), .ready(ready), .prog_req(prog_req),
    .prog_addr(prog_addr), .prog_data(prog_data), .id_mode(id_mode)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // scoreboard monitor: every program request must match the queue head
  always @(negedge clk) begin
    if (!rst && prog_req) begin
      if (exp_q.size() == 0) begin
        chk(1'b0, "R3 unexpected program request", 32'(prog_addr), 32'hFFFFFFFF);
      end else begin
        logic [ADDR_W+DATA_W-1:0] e;
        e = exp_q.pop_front();
        chk(prog_addr == e[ADDR_W+DATA_W-1:DATA_W], "R3 program address",
            32'(prog_addr), 32'(e[ADDR_W+DATA_W-1:DATA_W]));
        chk(prog_data == e[DATA_W-1:0], "R3 program data",
            32'(prog_data), 32'(e[DATA_W-1:0]));
      end
    end
  end

  // all tasks are entered and left at a negative edge
  task automatic bus_wr(input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] d);
    ce_n = 1'b0; we_n = 1'b0; oe_n = 1'b1; addr = a; dq = d;
    @(negedge clk); @(negedge clk);
    ce_n = 1'b1; we_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic bus_wr_oe_low(input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] d);
    ce_n = 1'b0; we_n = 1'b0; oe_n = 1'b0; addr = a; dq = d;
    @(negedge clk); @(negedge clk);
    ce_n = 1'b1; we_n = 1'b1; oe_n = 1'b1;
    @(negedge clk);
  endtask

  function automatic logic [ADDR_W-1:0] key_a(input bit bm, input int bank);
    return bm ? ADDR_W'((bank << 20) | 'hAAA) : ADDR_W'((bank << 19) | 'h555);
  endfunction

  function automatic logic [ADDR_W-1:0] key_b(input bit bm);
    return bm ? ADDR_W'('h555) : ADDR_W'('h2AA);
  endfunction

  task automatic unlock(input bit bm);
    bus_wr(key_a(bm, 0), 16'h00AA);
    bus_wr(key_b(bm), 16'h0055);
  endtask

  task automatic settle();
    @(negedge clk); @(negedge clk);
  endtask

  task automatic read_chk(input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] e,
                          input string tag);
    addr = a; ce_n = 1'b0; oe_n = 1'b0;
    @(negedge clk); @(negedge clk);
    chk(rd_data == e, tag, 32'(rd_data), 32'(e));
    ce_n = 1'b1; oe_n = 1'b1;
  endtask

  task automatic wait_req(input string tag);
    int n = 0;
    while (!prog_req && n < 50) begin @(negedge clk); n++; end
    chk(prog_req == 1'b1, tag, 32'(prog_req), 32'd1);
  endtask

  task automatic count_busy();
    int n = 0;
    while (!ready && n < 1000) begin n++; @(negedge clk); end
    chk(n == P, "R9 busy length", 32'(n), 32'(P));
  endtask

  task automatic expect_quiet(input string tag);
    bit low_seen = 0;
    for (int i = 0; i < P + 6; i++) begin
      @(negedge clk);
      if (!ready) low_seen = 1;
    end
    chk(!low_seen, tag, 32'(low_seen), 32'd0);
  endtask

  task automatic push(input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] d);
    exp_q.push_back({a, d});
  endtask

  task automatic finish_run();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    tests++; fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R12 reset state
    chk(ready == 1'b1, "R12 ready in reset", 32'(ready), 32'd1);
    chk(prog_req == 1'b0, "R12 prog_req in reset", 32'(prog_req), 32'd0);
    chk(id_mode == 1'b0, "R12 id_mode in reset", 32'(id_mode), 32'd0);
    chk(rd_data == 16'h0, "R12 rd_data in reset", 32'(rd_data), 32'd0);
    rst = 1'b0;
    @(negedge clk);

    // R13 registered array read path
    array_rdata = 16'h1357;
    read_chk(22'h000123, 16'h1357, "R13 array read");
    array_rdata = 16'h5A5A;

    // R3 / R9 / R11 word-mode program in bank 0
    unlock(0);
    bus_wr(key_a(0, 0), 16'h00A0);
    push(22'h000040, 16'hBEEF);
    bus_wr(22'h000040, 16'hBEEF);
    wait_req("R3 program request");
    chk(ready == 1'b0, "R9 ready low with request", 32'(ready), 32'd0);
    count_busy();
    chk(id_mode == 1'b0, "R11 read mode after program", 32'(id_mode), 32'd0);
    read_chk(22'h000000, 16'h5A5A, "R11 array data after program");

    // R5 / R6 identification in bank 1, word mode
    unlock(0);
    bus_wr(key_a(0, 1), 16'h0090);
    settle();
    chk(id_mode == 1'b1, "R5 id_mode entered", 32'(id_mode), 32'd1);
    read_chk(22'h080000, 16'h00EC, "R5 manufacturer code");
    read_chk(22'h080001, 16'h22A2, "R5 word device code");
    read_chk(22'h080003, 16'h0000, "R5 other offset");
    read_chk(22'h100000, 16'h5A5A, "R6 other bank reads array");
    // R7 non-reset write keeps id_mode, F0 clears it
    bus_wr(key_a(0, 0), 16'h00AA);
    settle();
    chk(id_mode == 1'b1, "R7 id_mode kept", 32'(id_mode), 32'd1);
    bus_wr(22'h000000, 16'h00F0);
    settle();
    chk(id_mode == 1'b0, "R7 F0 clears id_mode", 32'(id_mode), 32'd0);
    read_chk(22'h080000, 16'h5A5A, "R7 array after F0");

    // R4 / R5 byte mode identification and program
    byte_mode = 1'b1;
    unlock(1);
    bus_wr(key_a(1, 2), 16'h0090);
    settle();
    chk(id_mode == 1'b1, "R4 byte-mode unlock", 32'(id_mode), 32'd1);
    read_chk(22'h200000, 16'h00EC, "R5 byte manufacturer code");
    read_chk(22'h200002, 16'h0022, "R5 byte device code");
    read_chk(22'h200001, 16'h0000, "R5 byte other offset");
    bus_wr(22'h0, 16'h00F0);
    unlock(1);
    bus_wr(key_a(1, 3), 16'h00A0);
    push(22'h300105, 16'h00C3);
    bus_wr(22'h300105, 16'h00C3);
    wait_req("R4 byte program request");
    count_busy();
    // R4 word-mode addresses do not unlock in byte mode
    unlock(0);
    bus_wr(key_a(0, 0), 16'h00A0);
    bus_wr(22'h000010, 16'h1111);
    expect_quiet("R4 word addresses rejected in byte mode");
    byte_mode = 1'b0;

    // R6 program data in a different bank is dropped
    unlock(0);
    bus_wr(key_a(0, 1), 16'h00A0);
    bus_wr(22'h100010, 16'h2222);
    expect_quiet("R6 bank mismatch drops program");

    // R8 wrong second cycle returns to idle
    bus_wr(key_a(0, 0), 16'h00AA);
    bus_wr(key_b(0), 16'h0054);
    bus_wr(key_a(0, 0), 16'h00A0);
    bus_wr(22'h000020, 16'h3333);
    expect_quiet("R8 mismatch returns to idle");

    // R7 F0 aborts a partial sequence
    unlock(0);
    bus_wr(22'h000000, 16'h00F0);
    bus_wr(key_a(0, 0), 16'h00A0);
    bus_wr(22'h000030, 16'h4444);
    expect_quiet("R7 F0 aborts sequence");

    // R1 pulse with oe_n low is not a write
    unlock(0);
    bus_wr_oe_low(key_a(0, 0), 16'h00A0);
    bus_wr(key_a(0, 0), 16'h0090);
    settle();
    chk(id_mode == 1'b1, "R1 oe-low pulse ignored", 32'(id_mode), 32'd1);
    bus_wr(22'h0, 16'h00F0);

    // R2 address from first cycle, data from last cycle
    unlock(0);
    bus_wr(key_a(0, 0), 16'h00A0);
    push(22'h000077, 16'hD2D2);
    ce_n = 1'b0; we_n = 1'b0; oe_n = 1'b1; addr = 22'h000077; dq = 16'hD1D1;
    @(negedge clk);
    addr = 22'h000099; dq = 16'hD2D2;
    @(negedge clk);
    ce_n = 1'b1; we_n = 1'b1;
    @(negedge clk);
    wait_req("R2 shifted write request");
    count_busy();

    // R10 unlock write completing in the last busy cycle is ignored
    unlock(0);
    bus_wr(key_a(0, 0), 16'h00A0);
    push(22'h000050, 16'h0F0F);
    bus_wr(22'h000050, 16'h0F0F);
    wait_req("R10 program before race");
    repeat (P - 4) @(negedge clk);
    bus_wr(key_a(0, 0), 16'h00AA);
    bus_wr(key_b(0), 16'h0055);
    bus_wr(key_a(0, 0), 16'h0090);
    settle();
    chk(id_mode == 1'b0, "R10 write in last busy cycle ignored", 32'(id_mode), 32'd0);

    // R11 the same write one cycle later is accepted
    unlock(0);
    bus_wr(key_a(0, 0), 16'h00A0);
    push(22'h000060, 16'hF0F0);
    bus_wr(22'h000060, 16'hF0F0);
    wait_req("R11 program before race");
    repeat (P - 3) @(negedge clk);
    bus_wr(key_a(0, 0), 16'h00AA);
    bus_wr(key_b(0), 16'h0055);
    bus_wr(key_a(0, 0), 16'h0090);
    settle();
    chk(id_mode == 1'b1, "R11 write in first ready cycle accepted", 32'(id_mode), 32'd1);

    // R12 reset clears identification mode and partial sequences
    rst = 1'b1;
    @(negedge clk); @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(id_mode == 1'b0, "R12 reset clears id_mode", 32'(id_mode), 32'd0);
    unlock(0);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    bus_wr(key_a(0, 0), 16'h00A0);
    bus_wr(22'h000070, 16'h7777);
    expect_quiet("R12 reset discards partial sequence");

    chk(exp_q.size() == 0, "R3 all expected requests seen", 32'(exp_q.size()), 32'd0);
    finish_run();
  end

endmodule